// File: doc/BRIEF.md
# Sv32 Page Table Walker for Data Accesses

This block turns the virtual address of a data load or store into a physical address by walking a two-level Sv32 page table in memory. A core offers one request at a time. The request carries the virtual address, a store flag, the current privilege level and the satp value. The walker then reads at most two page table entries through a single read port. It returns either a physical address or a page fault. A fault response carries its cause code and the virtual address that faulted.

Translation runs only for supervisor-mode accesses while the satp mode bit is set. Every other request is answered on the next cycle with the address unchanged. The walker has no translation cache, so every translated access performs a full walk. It supports 4 KiB pages only and never writes a page table entry. A clear accessed bit, or a clear dirty bit on a store, causes a fault rather than an update. Supervisor access to a user page is always refused.

Top module: `pt_walker`

## Requirements
- R1: When satp bit 31 is 0, or the privilege input is not supervisor (encoding 2'b01, where 2'b11 is machine and 2'b00 is user), an accepted request is answered one cycle later with `rsp_pa` equal to the request address and no fault, and no page table read is issued.
- R2: The first page table read uses the address satp[21:0] shifted left by 12 plus VA[31:22] times 4, keeping the low 32 bits.
- R3: The second read uses the address formed by shifting the PPN field (bits 31:10) of the first-level entry left by 12 and adding VA[21:12] times 4. With a zero-wait memory, a full walk responds three cycles after acceptance and a first-level fault responds after two.
- R4: A successful walk returns bits 29:10 of the leaf entry (the low 20 bits of its PPN) followed by VA[11:0] as `rsp_pa`.
- R5: An entry whose valid bit (bit 0) is clear causes a fault, at either level.
- R6: A first-level entry with R (bit 1) or X (bit 3) set is a large-page leaf and causes a fault. An entry at either level with W (bit 2) set and R clear also causes a fault.
- R7: A second-level entry with V set and R, W and X all clear causes a fault.
- R8: A leaf causes a fault when a load finds R clear or a store finds W clear.
- R9: A leaf causes a fault when A (bit 6) is clear, or when a store finds D (bit 7) clear.
- R10: A leaf with U (bit 4) set causes a fault.
- R11: A fault reports cause 13 for a load and 15 for a store, and `rsp_tval` is the address captured at acceptance. Later changes to the request inputs do not affect the response.
- R12: `busy` is high from the cycle after acceptance up to and including the single cycle in which `rsp_valid` is high. Requests presented while `busy` is high are ignored.
- R13: While reset is asserted, `busy`, `mem_req_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_va | input | 32 | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_priv | input | 2 | Current privilege level |
| req_satp | input | 32 | Translation control: bit 31 is the mode, bits 21:0 are the root PPN |
| busy | output | 1 | A request is in flight |
| mem_req_valid | output | 1 | Page table read requested |
| mem_addr | output | 32 | Page table entry address |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 32 | Page table entry read back |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address; zero on a fault |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 4 | Fault cause, 13 or 15; zero without a fault |
| rsp_tval | output | 32 | Virtual address of the request |

## Verification
The checker assumes that requests are presented only after the internal reset synchronizer has released. It also assumes that the memory answers a read only while `mem_req_valid` is high. The bench waits several cycles after reset before driving anything. Its memory model raises `mem_rsp_valid` only in response to `mem_req_valid`, and it decodes only the two entry addresses it computes for each case, returning zero for any other address. A wrong address therefore shows up as an unexpected valid-bit fault.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int XLEN   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = 10;
  localparam int PPN_W  = 22;
  localparam int PTE_LG = 2;
  localparam int CAUSE_W = 4;
  localparam int PA_PPN_W = XLEN - OFF_W;

  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = 4'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = 4'd15;
  localparam logic [1:0]         PRIV_SUP       = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LVL1,
    ST_LVL0,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       rsw;
    logic             d;
    logic             a;
    logic             g;
    logic             u;
    logic             x;
    logic             w;
    logic             r;
    logic             v;
  } pte_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic             lvl0,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] l1_ppn,
  input  logic [XLEN-1:0]  va,
  output logic [XLEN-1:0]  pte_addr
);
  localparam int AW = PPN_W + OFF_W;

  logic [PPN_W-1:0] base;
  logic [VPN_W-1:0] idx;
  logic [AW-1:0]    full;
  logic             unused_hi;

  always_comb begin
    base = lvl0 ? l1_ppn : root_ppn;
    idx  = lvl0 ? va[OFF_W+VPN_W-1:OFF_W] : va[XLEN-1:OFF_W+VPN_W];
    full = {base, {OFF_W{1'b0}}} + AW'({idx, {PTE_LG{1'b0}}});
  end

  assign pte_addr  = full[XLEN-1:0];
  assign unused_hi = ^{full[AW-1:XLEN], va[OFF_W-1:0]};
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  pte_t pte,
  input  logic leaf_lvl,
  input  logic is_store,
  output logic fault
);
  logic bad_enc, is_ptr, perm_bad, ad_bad, unused_bits;

  always_comb begin
    bad_enc  = !pte.v || (pte.w && !pte.r);
    is_ptr   = !(pte.r || pte.w || pte.x);
    perm_bad = is_store ? !pte.w : !pte.r;
    ad_bad   = !pte.a || (is_store && !pte.d);
    if (leaf_lvl) fault = bad_enc || is_ptr || perm_bad || ad_bad || pte.u;
    else          fault = bad_enc || !is_ptr;
  end

  assign unused_bits = ^{pte.g, pte.rsw};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [XLEN-1:0]    req_va,
  input  logic               req_store,
  input  logic [1:0]         req_priv,
  input  logic [XLEN-1:0]    req_satp,
  output logic               busy,
  output logic               mem_req_valid,
  output logic [XLEN-1:0]    mem_addr,
  input  logic               mem_rsp_valid,
  input  logic [XLEN-1:0]    mem_rsp_data,
  output logic               rsp_valid,
  output logic [XLEN-1:0]    rsp_pa,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [XLEN-1:0]    rsp_tval
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  walk_state_e      state_q, state_d;
  logic [XLEN-1:0]  va_q, pa_q, pa_d;
  logic [PPN_W-1:0] root_q, l1ppn_q;
  logic             store_q, fault_q, fault_d, res_en;
  logic             accept, xlat_on, at_l0, pte_fault, l1_en;
  logic             unused_satp;
  pte_t             pte;

  assign pte         = pte_t'(mem_rsp_data);
  assign xlat_on     = req_satp[XLEN-1] && (req_priv == PRIV_SUP);
  assign accept      = req_valid && (state_q == ST_IDLE);
  assign at_l0       = (state_q == ST_LVL0);
  assign l1_en       = (state_q == ST_LVL1) && mem_rsp_valid;
  assign unused_satp = ^req_satp[XLEN-2:PPN_W];

  ptw_addr_gen u_addr (
    .lvl0     (at_l0),
    .root_ppn (root_q),
    .l1_ppn   (l1ppn_q),
    .va       (va_q),
    .pte_addr (mem_addr)
  );

  ptw_pte_eval u_eval (
    .pte      (pte),
    .leaf_lvl (at_l0),
    .is_store (store_q),
    .fault    (pte_fault)
  );

  // next-state and result selection
  always_comb begin
    state_d = state_q;
    res_en  = 1'b0;
    pa_d    = pa_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (xlat_on) begin
            state_d = ST_LVL1;
          end else begin
            state_d = ST_DONE;
            res_en  = 1'b1;
            pa_d    = req_va;
            fault_d = 1'b0;
          end
        end
      end
      ST_LVL1: begin
        if (mem_rsp_valid) begin
          if (pte_fault) begin
            state_d = ST_DONE;
            res_en  = 1'b1;
            pa_d    = '0;
            fault_d = 1'b1;
          end else begin
            state_d = ST_LVL0;
          end
        end
      end
      ST_LVL0: begin
        if (mem_rsp_valid) begin
          state_d = ST_DONE;
          res_en  = 1'b1;
          fault_d = pte_fault;
          pa_d    = pte_fault ? '0 : {pte.ppn[PA_PPN_W-1:0], va_q[OFF_W-1:0]};
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // request capture from the live inputs
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      va_q    <= '0;
      store_q <= 1'b0;
      root_q  <= '0;
    end else if (accept) begin
      va_q    <= req_va;
      store_q <= req_store;
      root_q  <= req_satp[PPN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  l1ppn_q <= '0;
    else if (l1_en)   l1ppn_q <= pte.ppn;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else if (res_en) begin
      pa_q    <= pa_d;
      fault_q <= fault_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_LVL1) || (state_q == ST_LVL0);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = fault_q;
  assign rsp_cause     = fault_q ? (store_q ? CAUSE_STORE_PF : CAUSE_LOAD_PF) : '0;
  assign rsp_tval      = va_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [XLEN-1:0]    req_va,
  input logic               req_store,
  input logic [1:0]         req_priv,
  input logic [XLEN-1:0]    req_satp,
  input logic               busy,
  input logic               mem_req_valid,
  input logic [XLEN-1:0]    mem_addr,
  input logic               mem_rsp_valid,
  input logic [XLEN-1:0]    mem_rsp_data,
  input logic               rsp_valid,
  input logic [XLEN-1:0]    rsp_pa,
  input logic               rsp_fault,
  input logic [CAUSE_W-1:0] rsp_cause,
  input logic [XLEN-1:0]    rsp_tval
);
  logic [XLEN-1:0] va_seen;
  logic            st_seen;
  logic            take;
  logic            unused_chk;

  assign take       = req_valid && !busy;
  assign unused_chk = ^{mem_addr, mem_rsp_valid, mem_rsp_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_seen <= '0;
      st_seen <= 1'b0;
    end else if (take) begin
      va_seen <= req_va;
      st_seen <= req_store;
    end
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(req_satp[XLEN-1] && req_priv == PRIV_SUP))
      |=> (rsp_valid && !rsp_fault && rsp_pa == $past(req_va)));

  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == va_seen[OFF_W-1:0]));

  p_tval_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_tval == va_seen));

  p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_cause == (st_seen ? 4'd15 : 4'd13)));

  p_memreq_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_single_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  import ptw_pkg::*;

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [1:0]  priv;
    logic        mode;
    logic [31:0] l1;
    logic [31:0] l0;
    logic        flt;
    logic [31:0] pa;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 17;
  localparam logic [21:0] ROOT = 22'h00080;

  localparam vec_t VECS [NV] = '{
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1443, 1'b0, 32'h12345678, 2'd3},
    '{32'hFFC01ABC, 1'b1, 2'b01, 1'b1, 32'h00020401, 32'h048D14C7, 1'b0, 32'h12345ABC, 2'd3},
    '{32'h12345678, 1'b1, 2'b01, 1'b1, 32'h00020401, 32'h048D1447, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1403, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1453, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b1, 2'b01, 1'b1, 32'h00020401, 32'h048D1443, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00000000, 32'h048D1443, 1'b1, 32'h00000000, 2'd2},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020403, 32'h048D1443, 1'b1, 32'h00000000, 2'd2},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1441, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1442, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1445, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D1449, 1'b1, 32'h00000000, 2'd3},
    '{32'h12345678, 1'b1, 2'b01, 1'b1, 32'h00020405, 32'h048D14C7, 1'b1, 32'h00000000, 2'd2},
    '{32'hDEADBEEF, 1'b0, 2'b01, 1'b0, 32'h00020401, 32'h048D1443, 1'b0, 32'hDEADBEEF, 2'd1},
    '{32'h00400010, 1'b0, 2'b11, 1'b1, 32'h00020401, 32'h048D1443, 1'b0, 32'h00400010, 2'd1},
    '{32'h7FFFF004, 1'b1, 2'b00, 1'b1, 32'h00020401, 32'h048D1443, 1'b0, 32'h7FFFF004, 2'd1},
    '{32'h00000FFF, 1'b0, 2'b01, 1'b1, 32'h00020401, 32'h048D144B, 1'b0, 32'h12345FFF, 2'd3}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 16:   return "R4";
      2, 3:       return "R9";
      4:          return "R10";
      5, 11:      return "R8";
      6, 9:       return "R5";
      7, 10, 12:  return "R6";
      8:          return "R7";
      default:    return "R1";
    endcase
  endfunction

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid, req_store;
  logic [31:0]        req_va, req_satp;
  logic [1:0]         req_priv;
  logic               busy, mem_req_valid, mem_rsp_valid, rsp_valid, rsp_fault;
  logic [31:0]        mem_addr, mem_rsp_data, rsp_pa, rsp_tval;
  logic [3:0]         rsp_cause;
  logic [31:0]        a1, a0, pte1, pte0;
  int                 nchk = 0;
  int                 nfail = 0;
  int                 nmem = 0;

  always #4 clk = ~clk;

  assign mem_rsp_valid = mem_req_valid;
  assign mem_rsp_data  = (mem_addr == a1) ? pte1 : (mem_addr == a0) ? pte0 : 32'h0;

  always @(posedge clk) if (mem_req_valid) nmem <= nmem + 1;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_store(req_store), .req_priv(req_priv), .req_satp(req_satp),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_tval(rsp_tval)
  );

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_addr(input logic [31:0] va);
    logic [33:0] t;
    t = {ROOT, 12'h000} + {22'h0, va[31:22], 2'b00};
    return t[31:0];
  endfunction

  function automatic logic [31:0] l0_addr(input logic [31:0] pte, input logic [31:0] va);
    logic [33:0] t;
    t = {pte[31:10], 12'h000} + {22'h0, va[21:12], 2'b00};
    return t[31:0];
  endfunction

  task automatic setup(input vec_t v);
    a1   = l1_addr(v.va);
    a0   = l0_addr(v.l1, v.va);
    pte1 = v.l1;
    pte0 = v.l0;
    req_va    = v.va;
    req_store = v.st;
    req_priv  = v.priv;
    req_satp  = {v.mode, 9'h0, ROOT};
  endtask

  task automatic wait_rsp(output int cyc);
    cyc = 1;
    while (!rsp_valid && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (R12) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_va = '0;
    req_priv = 2'b11; req_satp = '0; a1 = '1; a0 = '1; pte1 = '0; pte0 = '0;
    repeat (3) @(negedge clk);
    // R13: outputs quiet while in reset
    chk(!busy && !mem_req_valid && !rsp_valid, "R13 reset outputs",
        {29'h0, busy, mem_req_valid, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !rsp_valid, "R13 idle after reset", {30'h0, busy, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      setup(v);
      nmem = 0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp(cyc);
      chk(rsp_fault == v.flt, $sformatf("%s vec%0d fault flag", req_of(i), i),
          {31'h0, rsp_fault}, {31'h0, v.flt});
      if (!v.flt)
        chk(rsp_pa == v.pa, $sformatf("R4 vec%0d physical address (R2 R3 entry addresses)", i),
            rsp_pa, v.pa);
      else begin
        chk(rsp_cause == (v.st ? 4'd15 : 4'd13), $sformatf("R11 vec%0d cause", i),
            {28'h0, rsp_cause}, v.st ? 32'd15 : 32'd13);
        chk(rsp_tval == v.va, $sformatf("R11 vec%0d trap value", i), rsp_tval, v.va);
      end
      chk(cyc == int'(v.lat), $sformatf("R3 vec%0d response latency", i), cyc, {30'h0, v.lat});
      @(negedge clk);
      chk(nmem == int'(v.lat) - 1, $sformatf("%s vec%0d table reads (R2)",
          (v.lat == 2'd1) ? "R1" : "R3", i), nmem, int'(v.lat) - 1);
    end

    // R12/R11: inputs change mid-walk and a second request is held; both ignored
    setup(VECS[9]);
    req_valid = 1'b1;
    @(negedge clk);
    chk(busy, "R12 busy after accept", {31'h0, busy}, 32'h1);
    req_va = 32'h0ABCD123; req_store = 1'b1; req_satp = 32'h0;
    wait_rsp(cyc);
    req_valid = 1'b0;
    chk(rsp_fault && rsp_tval == 32'h12345678, "R11 live capture of address",
        rsp_tval, 32'h12345678);
    chk(rsp_cause == 4'd13, "R11 load flag captured at accept", {28'h0, rsp_cause}, 32'd13);
    chk(busy, "R12 busy during response", {31'h0, busy}, 32'h1);
    @(negedge clk);
    chk(!busy && !rsp_valid, "R12 held request ignored", {30'h0, busy, rsp_valid}, 32'h0);

    // R13: reset during a walk
    setup(VECS[0]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!busy && !mem_req_valid && !rsp_valid, "R13 reset mid-walk",
        {29'h0, busy, mem_req_valid, rsp_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule